// File: doc/BRIEF.md
# DRAM Per-Bank Row State Tracker

This block keeps a small open-row table for a DRAM device: one entry for each bank, made of an open flag and the row address that the last activate latched. A command scheduler reports every command it issues on one or more issue lanes. The tracker updates the table from that stream one clock later. Activates open a row. Precharges of every kind, auto-precharge column commands and self-refresh entry close it. Other commands leave the table as it was.

The same table also serves a lookup port. For a queued request, given its bank, row, direction and page policy, the tracker reports which command the scheduler has to issue next. That command is an activate when the bank is closed, a precharge on a row conflict, and a column read or write on a row hit. The page-policy input chooses between the plain column command and its auto-precharge form. The lookup is combinational from the registered table, so a scheduler can scan candidates in the same cycle it picks one.

Top module: `row_state_tracker`

## Requirements
- R1: While reset is asserted, and right after it, every bank reads closed (bank_open all zero). Any request then decodes to activate.
- R2: Command code 1 (activate) and code 2 (bank-variant activate) on a valid lane set the addressed bank open. They also store the lane's row in that bank's slice of bank_row, which is bits bank*ROW_W upward.
- R3: Codes 3 (precharge), 4 (bank-variant precharge), 7 (read with auto-precharge), 9 (write with auto-precharge) and 11 (self-refresh entry) close only the addressed bank.
- R4: Code 5 (precharge-all) closes every bank, whatever bank field it carries.
- R5: The table is left untouched by any of the following: code 6 (read), code 8 (write), code 10 (all-bank refresh), code 0 (no-op), codes 12 to 15, and any lane whose valid bit is low.
- R6: When the requested bank is closed, next_cmd is 1 (activate).
- R7: When the requested bank is open on a row other than req_row, next_cmd is 3 (precharge).
- R8: On a row hit with req_close_page low, next_cmd is 6 (read) for req_is_write low and 8 (write) for req_is_write high.
- R9: On a row hit with req_close_page high, next_cmd is 7 (read with auto-precharge) or 9 (write with auto-precharge).
- R10: When lanes in the same cycle both close and open one bank, the close wins and the bank ends closed. When two lanes activate the same bank, the row from the lowest-numbered lane is stored.
- R11: A command changes bank_open, bank_row and next_cmd at the first rising clock edge after it is presented, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | LANES | Issue strobe for each lane |
| cmd_code | input | 4*LANES | Command code for each lane, lane l in bits 4l upward |
| cmd_bank | input | BANK_W*LANES | Target bank for each lane |
| cmd_row | input | ROW_W*LANES | Row for each lane, used by activates |
| req_bank | input | BANK_W | Bank of the queued request |
| req_row | input | ROW_W | Row of the queued request |
| req_is_write | input | 1 | High for a write request |
| req_close_page | input | 1 | High selects closed-page policy |
| bank_open | output | NBANK | Open flag for each bank |
| bank_row | output | ROW_W*NBANK | Latched row for each bank |
| next_cmd | output | 4 | Next command required by the request |

## Verification
The properties assume that NBANK is a power of two, so every value of req_bank and cmd_bank names a real bank. They also assume that the issue lanes never hold X while reset is released. The bench drives only banks 0 to 7 with the default eight-bank build and sets every lane field at each falling edge. Command values the protocol does not define (codes 12 to 15) are driven on purpose. They are covered by the stability property because they must not touch the table.

// File: rtl/rowtrk_pkg.sv
package rowtrk_pkg;

   typedef enum logic [3:0] {
      CMD_NOP    = 4'd0,
      CMD_ACT    = 4'd1,
      CMD_ACTB   = 4'd2,
      CMD_PRE    = 4'd3,
      CMD_PREB   = 4'd4,
      CMD_PREALL = 4'd5,
      CMD_RD     = 4'd6,
      CMD_RDAP   = 4'd7,
      CMD_WR     = 4'd8,
      CMD_WRAP   = 4'd9,
      CMD_REF    = 4'd10,
      CMD_SRE    = 4'd11
   } cmd_e;

   localparam int CMD_W = 4;

   typedef struct packed {
      logic opens;
      logic closes_one;
      logic closes_all;
   } cmd_effect_t;

endpackage

// File: rtl/rowtrk_cmd_decode.sv
module rowtrk_cmd_decode
   import rowtrk_pkg::*;
(
   input  logic             valid,
   input  logic [CMD_W-1:0] code,
   output cmd_effect_t      effect
);

   always_comb begin
      effect = '0;
      if (valid) begin
         unique case (code)
            CMD_ACT, CMD_ACTB:                         effect.opens      = 1'b1;
            CMD_PRE, CMD_PREB, CMD_RDAP, CMD_WRAP,
            CMD_SRE:                                   effect.closes_one = 1'b1;
            CMD_PREALL:                                effect.closes_all = 1'b1;
            default:                                   effect = '0;
         endcase
      end
   end

endmodule

// File: rtl/rowtrk_bank_slot.sv
module rowtrk_bank_slot
   import rowtrk_pkg::*;
#(
   parameter int IDX    = 0,
   parameter int LANES  = 2,
   parameter int BANK_W = 3,
   parameter int ROW_W  = 14
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  cmd_effect_t [LANES-1:0]           eff,
   input  logic        [LANES-1:0][BANK_W-1:0] lane_bank,
   input  logic        [LANES-1:0][ROW_W-1:0]  lane_row,
   output logic                              open_q,
   output logic        [ROW_W-1:0]           row_q
);

   localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(IDX);

   logic             close_req;
   logic             open_req;
   logic [ROW_W-1:0] open_row;

   // Lowest lane wins among activates: scan downward so lane 0 is applied last.
   always_comb begin
      close_req = 1'b0;
      open_req  = 1'b0;
      open_row  = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
         if (eff[l].closes_all) close_req = 1'b1;
         if (eff[l].closes_one && (lane_bank[l] == MY_BANK)) close_req = 1'b1;
         if (eff[l].opens && (lane_bank[l] == MY_BANK)) begin
            open_req = 1'b1;
            open_row = lane_row[l];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
      end else if (close_req) begin
         open_q <= 1'b0;
      end else if (open_req) begin
         open_q <= 1'b1;
         row_q  <= open_row;
      end
   end

endmodule

// File: rtl/rowtrk_lookup.sv
module rowtrk_lookup
   import rowtrk_pkg::*;
#(
   parameter int NBANK  = 8,
   parameter int BANK_W = 3,
   parameter int ROW_W  = 14
) (
   input  logic [NBANK-1:0]            open_vec,
   input  logic [NBANK-1:0][ROW_W-1:0] row_vec,
   input  logic [BANK_W-1:0]           req_bank,
   input  logic [ROW_W-1:0]            req_row,
   input  logic                        req_is_write,
   input  logic                        req_close_page,
   output logic [CMD_W-1:0]            next_cmd
);

   logic             sel_open;
   logic [ROW_W-1:0] sel_row;
   cmd_e             pick;

   assign sel_open = open_vec[req_bank];
   assign sel_row  = row_vec[req_bank];

   always_comb begin
      if (!sel_open)                pick = CMD_ACT;
      else if (sel_row != req_row)  pick = CMD_PRE;
      else if (req_is_write)        pick = req_close_page ? CMD_WRAP : CMD_WR;
      else                          pick = req_close_page ? CMD_RDAP : CMD_RD;
   end

   assign next_cmd = pick;

endmodule

// File: rtl/row_state_tracker.sv
module row_state_tracker
   import rowtrk_pkg::*;
#(
   parameter int NBANK  = 8,
   parameter int ROW_W  = 14,
   parameter int LANES  = 2,
   localparam int BANK_W = $clog2(NBANK)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [LANES-1:0]          cmd_valid,
   input  logic [CMD_W*LANES-1:0]    cmd_code,
   input  logic [BANK_W*LANES-1:0]   cmd_bank,
   input  logic [ROW_W*LANES-1:0]    cmd_row,
   input  logic [BANK_W-1:0]         req_bank,
   input  logic [ROW_W-1:0]          req_row,
   input  logic                      req_is_write,
   input  logic                      req_close_page,
   output logic [NBANK-1:0]          bank_open,
   output logic [ROW_W*NBANK-1:0]    bank_row,
   output logic [CMD_W-1:0]          next_cmd
);

   generate
      if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
         $error("row_state_tracker: NBANK must be a power of two, at least 2");
      end
      if (ROW_W < 1) begin : g_bad_row
         $error("row_state_tracker: ROW_W must be positive");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("row_state_tracker: LANES must be positive");
      end
   endgenerate

   cmd_effect_t [LANES-1:0]             eff;
   logic        [LANES-1:0][BANK_W-1:0] lane_bank;
   logic        [LANES-1:0][ROW_W-1:0]  lane_row;
   logic        [NBANK-1:0]             open_vec;
   logic        [NBANK-1:0][ROW_W-1:0]  row_vec;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign lane_bank[l] = cmd_bank[l*BANK_W +: BANK_W];
         assign lane_row[l]  = cmd_row[l*ROW_W +: ROW_W];
         rowtrk_cmd_decode u_dec (
            .valid  (cmd_valid[l]),
            .code   (cmd_code[l*CMD_W +: CMD_W]),
            .effect (eff[l])
         );
      end

      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         rowtrk_bank_slot #(
            .IDX    (b),
            .LANES  (LANES),
            .BANK_W (BANK_W),
            .ROW_W  (ROW_W)
         ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .eff       (eff),
            .lane_bank (lane_bank),
            .lane_row  (lane_row),
            .open_q    (open_vec[b]),
            .row_q     (row_vec[b])
         );
      end
   endgenerate

   rowtrk_lookup #(
      .NBANK  (NBANK),
      .BANK_W (BANK_W),
      .ROW_W  (ROW_W)
   ) u_lookup (
      .open_vec       (open_vec),
      .row_vec        (row_vec),
      .req_bank       (req_bank),
      .req_row        (req_row),
      .req_is_write   (req_is_write),
      .req_close_page (req_close_page),
      .next_cmd       (next_cmd)
   );

   assign bank_open = open_vec;
   assign bank_row  = row_vec;

endmodule

// File: rtl/row_state_tracker_chk.sv
module row_state_tracker_chk #(
   parameter int NBANK  = 8,
   parameter int ROW_W  = 14,
   parameter int LANES  = 2,
   localparam int BANK_W = $clog2(NBANK)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [LANES-1:0]        cmd_valid,
   input logic [4*LANES-1:0]      cmd_code,
   input logic [BANK_W*LANES-1:0] cmd_bank,
   input logic [ROW_W*LANES-1:0]  cmd_row,
   input logic [BANK_W-1:0]       req_bank,
   input logic [ROW_W-1:0]        req_row,
   input logic                    req_is_write,
   input logic                    req_close_page,
   input logic [NBANK-1:0]        bank_open,
   input logic [ROW_W*NBANK-1:0]  bank_row,
   input logic [3:0]              next_cmd
);

   logic             any_prea;
   logic             any_touch;
   logic             sel_open;
   logic [ROW_W-1:0] sel_row;

   always_comb begin
      any_prea  = 1'b0;
      any_touch = 1'b0;
      for (int l = 0; l < LANES; l++) begin
         if (cmd_valid[l] && cmd_code[l*4 +: 4] == 4'd5) any_prea = 1'b1;
         if (cmd_valid[l] && (cmd_code[l*4 +: 4] inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd7, 4'd9, 4'd11}))
            any_touch = 1'b1;
      end
   end

   assign sel_open = bank_open[req_bank];
   assign sel_row  = bank_row[int'(req_bank)*ROW_W +: ROW_W];

   AST_RESET_CLOSED: assert property (@(posedge clk) !rst_n |-> bank_open == '0); // R1

   AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      any_prea |=> bank_open == '0); // R4

   AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !any_touch |=> $stable(bank_open) && $stable(bank_row)); // R5

   AST_CLOSED_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_open |-> next_cmd == 4'd1); // R6

   AST_CONFLICT_NEEDS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_open && sel_row != req_row) |-> next_cmd == 4'd3); // R7

   AST_HIT_OPEN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_open && sel_row == req_row && !req_close_page) |->
         next_cmd == (req_is_write ? 4'd8 : 4'd6)); // R8

   AST_HIT_CLOSED_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_open && sel_row == req_row && req_close_page) |->
         next_cmd == (req_is_write ? 4'd9 : 4'd7)); // R9

endmodule

bind row_state_tracker row_state_tracker_chk #(
   .NBANK (NBANK),
   .ROW_W (ROW_W),
   .LANES (LANES)
) u_chk (.*);

// File: tb/row_state_tracker_tb.sv
module row_state_tracker_tb;

   localparam int NBANK  = 8;
   localparam int ROW_W  = 14;
   localparam int LANES  = 2;
   localparam int BANK_W = 3;
   localparam int NVEC   = 18;

   typedef struct packed {
      logic        v0;
      logic [3:0]  c0;
      logic [2:0]  b0;
      logic [13:0] r0;
      logic        v1;
      logic [3:0]  c1;
      logic [2:0]  b1;
      logic [13:0] r1;
      logic [2:0]  qb;
      logic [13:0] qr;
      logic        qw;
      logic        qc;
      logic [3:0]  en;
      logic [7:0]  eo;
   } vec_t;

   // Each entry: lane0, lane1, request, expected next_cmd and bank_open after the edge.
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 4'd1,  3'd0, 14'h0123, 1'b0, 4'd0,  3'd0, 14'h0,    3'd0, 14'h0123, 1'b0, 1'b0, 4'd6, 8'h01}, // R2 R8
      '{1'b0, 4'd0,  3'd0, 14'h0,    1'b0, 4'd0,  3'd0, 14'h0,    3'd0, 14'h0123, 1'b1, 1'b1, 4'd9, 8'h01}, // R9
      '{1'b1, 4'd2,  3'd3, 14'h3FFF, 1'b0, 4'd0,  3'd0, 14'h0,    3'd3, 14'h3FFF, 1'b0, 1'b1, 4'd7, 8'h09}, // R2 R9
      '{1'b1, 4'd6,  3'd0, 14'h0,    1'b0, 4'd0,  3'd0, 14'h0,    3'd0, 14'h0124, 1'b0, 1'b0, 4'd3, 8'h09}, // R5 R7
      '{1'b1, 4'd8,  3'd3, 14'h0,    1'b1, 4'd10, 3'd5, 14'h0,    3'd3, 14'h3FFF, 1'b1, 1'b0, 4'd8, 8'h09}, // R5 R8
      '{1'b1, 4'd7,  3'd0, 14'h0,    1'b0, 4'd0,  3'd0, 14'h0,    3'd0, 14'h0123, 1'b0, 1'b0, 4'd1, 8'h08}, // R3 R6
      '{1'b1, 4'd1,  3'd7, 14'h0001, 1'b1, 4'd1,  3'd1, 14'h2000, 3'd7, 14'h0001, 1'b0, 1'b0, 4'd6, 8'h8A}, // R2
      '{1'b1, 4'd9,  3'd1, 14'h0,    1'b0, 4'd0,  3'd0, 14'h0,    3'd1, 14'h2000, 1'b0, 1'b0, 4'd1, 8'h88}, // R3
      '{1'b1, 4'd4,  3'd3, 14'h0,    1'b0, 4'd0,  3'd0, 14'h0,    3'd3, 14'h3FFF, 1'b0, 1'b0, 4'd1, 8'h80}, // R3
      '{1'b1, 4'd1,  3'd2, 14'h0005, 1'b1, 4'd11, 3'd7, 14'h0,    3'd2, 14'h0006, 1'b0, 1'b0, 4'd3, 8'h04}, // R3 R7
      '{1'b1, 4'd1,  3'd4, 14'h0009, 1'b1, 4'd2,  3'd5, 14'h000A, 3'd5, 14'h000A, 1'b1, 1'b1, 4'd9, 8'h34}, // R2 R9
      '{1'b1, 4'd5,  3'd1, 14'h0,    1'b0, 4'd0,  3'd0, 14'h0,    3'd4, 14'h0009, 1'b0, 1'b0, 4'd1, 8'h00}, // R4
      '{1'b1, 4'd1,  3'd6, 14'h0077, 1'b1, 4'd5,  3'd2, 14'h0,    3'd6, 14'h0077, 1'b0, 1'b0, 4'd1, 8'h00}, // R10
      '{1'b1, 4'd1,  3'd6, 14'h0011, 1'b1, 4'd3,  3'd6, 14'h0,    3'd6, 14'h0011, 1'b0, 1'b0, 4'd1, 8'h00}, // R10
      '{1'b1, 4'd1,  3'd6, 14'h0022, 1'b1, 4'd2,  3'd6, 14'h0033, 3'd6, 14'h0022, 1'b0, 1'b0, 4'd6, 8'h40}, // R10
      '{1'b1, 4'd12, 3'd6, 14'h0,    1'b1, 4'd15, 3'd6, 14'h0,    3'd6, 14'h0022, 1'b1, 1'b0, 4'd8, 8'h40}, // R5
      '{1'b0, 4'd3,  3'd6, 14'h0,    1'b0, 4'd5,  3'd0, 14'h0,    3'd6, 14'h0022, 1'b0, 1'b0, 4'd6, 8'h40}, // R5
      '{1'b1, 4'd3,  3'd6, 14'h0,    1'b0, 4'd0,  3'd0, 14'h0,    3'd6, 14'h0022, 1'b0, 1'b0, 4'd1, 8'h00}  // R3
   };

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [LANES-1:0]        cmd_valid = '0;
   logic [4*LANES-1:0]      cmd_code = '0;
   logic [BANK_W*LANES-1:0] cmd_bank = '0;
   logic [ROW_W*LANES-1:0]  cmd_row = '0;
   logic [BANK_W-1:0]       req_bank = '0;
   logic [ROW_W-1:0]        req_row = '0;
   logic                    req_is_write = 1'b0;
   logic                    req_close_page = 1'b0;
   logic [NBANK-1:0]        bank_open;
   logic [ROW_W*NBANK-1:0]  bank_row;
   logic [3:0]              next_cmd;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   row_state_tracker #(.NBANK(NBANK), .ROW_W(ROW_W), .LANES(LANES)) u_dut (
      .clk, .rst_n, .cmd_valid, .cmd_code, .cmd_bank, .cmd_row,
      .req_bank, .req_row, .req_is_write, .req_close_page,
      .bank_open, .bank_row, .next_cmd
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle_lanes();
      cmd_valid = '0;
      cmd_code  = '0;
      cmd_bank  = '0;
      cmd_row   = '0;
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 open flags in reset", 32'(bank_open), 32'h0);
      check("R1 next_cmd in reset", 32'(next_cmd), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 open flags after reset", 32'(bank_open), 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         cmd_valid      = {VEC[i].v1, VEC[i].v0};
         cmd_code       = {VEC[i].c1, VEC[i].c0};
         cmd_bank       = {VEC[i].b1, VEC[i].b0};
         cmd_row        = {VEC[i].r1, VEC[i].r0};
         req_bank       = VEC[i].qb;
         req_row        = VEC[i].qr;
         req_is_write   = VEC[i].qw;
         req_close_page = VEC[i].qc;
         @(negedge clk);
         check($sformatf("vector %0d next_cmd", i), 32'(next_cmd), 32'(VEC[i].en));
         check($sformatf("vector %0d bank_open", i), 32'(bank_open), 32'(VEC[i].eo));
      end

      // R10: two activates on one bank, lowest lane's row is stored (from vector 14)
      check("R10 stored row lane0", 32'(bank_row[6*ROW_W +: ROW_W]), 32'h0022);

      // R11 and R2: update lands only at the next rising edge
      idle_lanes();
      cmd_valid = 2'b01;
      cmd_code  = 8'h01;
      cmd_bank  = 6'd2;
      cmd_row   = {14'h0, 14'h1ABC};
      req_bank  = 3'd2;
      req_row   = 14'h1ABC;
      req_is_write = 1'b0;
      req_close_page = 1'b0;
      #1;
      check("R11 no early update", 32'(next_cmd), 32'd1);
      check("R11 bank closed before edge", 32'(bank_open[2]), 32'd0);
      @(negedge clk);
      check("R11 next_cmd after edge", 32'(next_cmd), 32'd6);
      check("R2 row slice bank2", 32'(bank_row[2*ROW_W +: ROW_W]), 32'h1ABC);

      // R1: asynchronous reset clears open banks
      idle_lanes();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 async reset clears", 32'(bank_open), 32'h0);
      check("R1 next_cmd activate in reset", 32'(next_cmd), 32'd1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 closed after release", 32'(bank_open), 32'h0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule